// File: doc/BRIEF.md
# Processor Stop-Clock Power-State Controller

This block tracks the low-power state of a processor core and turns that state into clock-gate enables and one-cycle event-service strobes. It has six states. The core leaves normal operation when it executes a halt or when the system requests a clock stop. A halted core wakes on an interrupt-class event. A stopped core can go further down to sleep, and from sleep to deep sleep once the bus clock goes away. Snoops are serviced from auto-halt and from stop-grant in a dedicated snoop state. In each case the controller returns to the state it came from.

Events are handled differently in each state. In normal operation they are serviced at once. In auto-halt they wake the core, except for flush, which is serviced in place. In stop-grant and in the snoop state, the interrupt-class events are held in one pending bit each and replayed once on the way back to normal. In sleep and deep sleep every event is dropped. The bus clock is not sampled directly. A monitor on the free-running controller clock counts cycles since the last bus-clock edge and declares the clock absent after a parameterised quiet period.

Top module: `lps_ctrl`

## Requirements
- R1: After the block reset, `state_out` is 1 (normal), `core_clk_en`, `bus_clk_en` and `snoop_ok` are 1, and `evt_svc` and `halt_cycle` are 0.
- R2: State codes are 1 normal, 2 auto-halt, 3 stop-grant, 4 snoop, 5 sleep, 6 deep sleep. In normal with `stpclk_req` low, `halt_exec` moves to auto-halt and raises `halt_cycle` for exactly that one cycle. In normal, `stpclk_req` takes precedence over `halt_exec`.
- R3: Event bits are 0 SMI, 1 INIT, 2 NMI, 3 INTR, 4 BINIT, 5 FLUSH, 6 RESET. In auto-halt, RESET returns to normal and strobes only bit 6. Otherwise, any of bits 0 to 4 returns to normal and strobes every asserted bit 0 to 5.
- R4: In auto-halt, FLUSH on its own strobes bit 5 for one cycle and the state stays 2.
- R5: `stpclk_req` high in normal or auto-halt enters stop-grant. Dropping it returns to the state of origin.
- R6: `snoop_hit` in auto-halt or stop-grant enters state 4. `snoop_done` returns to the state of origin.
- R7: `slp_req` high in stop-grant enters sleep, and dropping it returns to stop-grant. Dropping `slp_req` takes precedence over bus-clock loss. Bus-clock loss in sleep enters deep sleep, and its return goes back to sleep.
- R8: In stop-grant, BINIT and FLUSH produce no strobe and no state change. RESET strobes bit 6, keeps the state at 3, and discards pending events.
- R9: In states 3 and 4, bits 0 to 3 are each captured into one pending bit. On the cycle the state becomes 1, each pending event strobes exactly once, however many times it arrived.
- R10: In sleep and deep sleep, `snoop_ok` is 0 and every event and snoop input is ignored. `bus_clk_en` is 0 only in deep sleep.
- R11: `core_clk_en` is 1 in states 1, 2 and 4. In states 3, 5 and 6 it is the inverse of `gate_all`.
- R12: The bus clock is declared absent after `ABSENT_LIMIT` controller cycles with no edge on `bclk_in`, and present again soon after edges resume.
- R13: In normal, every asserted event bit is strobed in the same cycle, and RESET alone leaves the state at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high block reset |
| bclk_in | input | 1 | Bus clock, sampled as data |
| gate_all | input | 1 | Gate all core clocks in stop-grant, sleep and deep sleep |
| halt_exec | input | 1 | Halt instruction executed |
| stpclk_req | input | 1 | Stop-clock request level |
| slp_req | input | 1 | Sleep request level |
| snoop_hit | input | 1 | Snoop detected on the bus |
| snoop_done | input | 1 | Snoop servicing finished |
| evt_in | input | 7 | Event lines (bit map in R3) |
| state_out | output | 3 | Current state code |
| core_clk_en | output | 1 | Internal clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| halt_cycle | output | 1 | One-cycle halt bus-cycle strobe |
| evt_svc | output | 7 | One-cycle event service strobes |
| snoop_ok | output | 1 | Snoops and interrupts accepted |

## Verification
A cycle-accurate reference model is driven with random stimulus that mixes level requests with sparse event and snoop strobes. This reaches many state paths, including events that coincide with a state exit. Directed sequences separate the cases that random traffic rarely tells apart. One is repeated SMI while stopped, which must give a single replay strobe. Another is RESET while stopped, which must discard pending events. The others are FLUSH alone in auto-halt versus FLUSH together with a wake event, and the stop-grant exit that returns to auto-halt versus the one that returns to normal. A quiet bus clock while in sleep checks the deep-sleep entry window, and the restart checks the return path.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd1,
    ST_HALT   = 3'd2,
    ST_STOPG  = 3'd3,
    ST_SNOOP  = 3'd4,
    ST_SLEEP  = 3'd5,
    ST_DEEP   = 3'd6
  } lps_state_e;

  localparam int NUM_EV    = 7;
  localparam int NUM_LATCH = 4;
  localparam int EV_SMI    = 0;
  localparam int EV_INIT   = 1;
  localparam int EV_NMI    = 2;
  localparam int EV_INTR   = 3;
  localparam int EV_BINIT  = 4;
  localparam int EV_FLUSH  = 5;
  localparam int EV_RESET  = 6;

  // events that end auto-halt
  localparam logic [NUM_EV-1:0] WAKE_MASK = NUM_EV'((1 << EV_SMI) | (1 << EV_INIT) |
      (1 << EV_NMI) | (1 << EV_INTR) | (1 << EV_BINIT));
  localparam logic [NUM_EV-1:0] FLUSH_MASK = NUM_EV'(1 << EV_FLUSH);
endpackage

// File: rtl/lps_clkmon.sv
module lps_clkmon #(
  parameter int LIMIT = 8,
  parameter int SYNC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  output logic present_q
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [SYNC:0]   sh_q;
  logic [CW-1:0]   cnt_q;
  logic            edge_w;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC-1:0], bclk_in};
  end

  assign edge_w = sh_q[SYNC] ^ sh_q[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (edge_w)       cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) present_q <= 1'b1;
    else     present_q <= (cnt_q != LIM);
  end

  // R12
  edge_keeps_present_chk: assert property (@(posedge clk) disable iff (rst)
    edge_w |-> ##2 present_q);
endmodule

// File: rtl/lps_pending.sv
module lps_pending #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         release_i,
  input  logic [N-1:0] capture,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] drained
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear)    pend_q[i] <= 1'b0;
      else if (release_i)  pend_q[i] <= 1'b0;
      else if (capture[i]) pend_q[i] <= 1'b1;
    end
    assign drained[i] = release_i & (pend_q[i] | capture[i]);
  end

  // R9
  drain_empties_chk: assert property (@(posedge clk) disable iff (rst)
    release_i |=> (pend_q == '0));
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm import lps_pkg::*; (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gate_all,
  input  logic                 bclk_present,
  input  logic                 halt_exec,
  input  logic                 stpclk_req,
  input  logic                 slp_req,
  input  logic                 snoop_hit,
  input  logic                 snoop_done,
  input  logic [NUM_EV-1:0]    evt,
  input  logic [NUM_LATCH-1:0] drained,
  output logic [NUM_LATCH-1:0] cap,
  output logic                 release_o,
  output logic                 clear_o,
  output lps_state_e           state_q,
  output logic                 core_en_q,
  output logic                 bus_en_q,
  output logic                 halt_q,
  output logic [NUM_EV-1:0]    svc_q,
  output logic                 snoop_ok_q
);
  lps_state_e          nxt;
  logic                sg_halt_q, sg_halt_n;
  logic                sn_halt_q, sn_halt_n;
  logic [NUM_EV-1:0]   svc_base;
  logic                halt_n;
  logic                low_pwr_n;

  always_comb begin
    nxt       = state_q;
    sg_halt_n = sg_halt_q;
    sn_halt_n = sn_halt_q;
    svc_base  = '0;
    halt_n    = 1'b0;
    cap       = '0;
    clear_o   = 1'b0;
    case (state_q)
      ST_NORMAL: begin
        svc_base = evt;
        clear_o  = evt[EV_RESET];
        if (stpclk_req) begin
          nxt       = ST_STOPG;
          sg_halt_n = 1'b0;
        end else if (halt_exec) begin
          nxt    = ST_HALT;
          halt_n = 1'b1;
        end
      end
      ST_HALT: begin
        if (evt[EV_RESET]) begin
          nxt                = ST_NORMAL;
          svc_base[EV_RESET] = 1'b1;
          clear_o            = 1'b1;
        end else if ((evt & WAKE_MASK) != '0) begin
          nxt      = ST_NORMAL;
          svc_base = evt & (WAKE_MASK | FLUSH_MASK);
        end else begin
          svc_base[EV_FLUSH] = evt[EV_FLUSH];
          if (stpclk_req) begin
            nxt       = ST_STOPG;
            sg_halt_n = 1'b1;
          end else if (snoop_hit) begin
            nxt       = ST_SNOOP;
            sn_halt_n = 1'b1;
          end
        end
      end
      ST_STOPG: begin
        if (evt[EV_RESET]) begin
          svc_base[EV_RESET] = 1'b1;
          clear_o            = 1'b1;
        end else begin
          cap = evt[NUM_LATCH-1:0];
        end
        if (!stpclk_req) begin
          nxt = sg_halt_q ? ST_HALT : ST_NORMAL;
        end else if (slp_req) begin
          nxt = ST_SLEEP;
        end else if (snoop_hit) begin
          nxt       = ST_SNOOP;
          sn_halt_n = 1'b0;
        end
      end
      ST_SNOOP: begin
        if (evt[EV_RESET]) begin
          svc_base[EV_RESET] = 1'b1;
          clear_o            = 1'b1;
        end else begin
          cap = evt[NUM_LATCH-1:0];
        end
        if (snoop_done) nxt = sn_halt_q ? ST_HALT : ST_STOPG;
      end
      ST_SLEEP: begin
        if (!slp_req)          nxt = ST_STOPG;
        else if (!bclk_present) nxt = ST_DEEP;
      end
      ST_DEEP: begin
        if (bclk_present) nxt = ST_SLEEP;
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  assign release_o = (nxt == ST_NORMAL) && (state_q != ST_NORMAL) && !clear_o;
  assign low_pwr_n = (nxt == ST_STOPG) || (nxt == ST_SLEEP) || (nxt == ST_DEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_NORMAL;
      sg_halt_q  <= 1'b0;
      sn_halt_q  <= 1'b0;
      core_en_q  <= 1'b1;
      bus_en_q   <= 1'b1;
      halt_q     <= 1'b0;
      svc_q      <= '0;
      snoop_ok_q <= 1'b1;
    end else begin
      state_q    <= nxt;
      sg_halt_q  <= sg_halt_n;
      sn_halt_q  <= sn_halt_n;
      core_en_q  <= !(gate_all && low_pwr_n);
      bus_en_q   <= (nxt != ST_DEEP);
      halt_q     <= halt_n;
      svc_q      <= svc_base | {{(NUM_EV-NUM_LATCH){1'b0}}, drained};
      snoop_ok_q <= !((nxt == ST_SLEEP) || (nxt == ST_DEEP));
    end
  end

  // R2
  halt_strobe_state_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> (state_q == ST_HALT));
  // R10
  sleep_silent_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SLEEP) || (state_q == ST_DEEP)) |=> (svc_q == '0));
  // R10
  deep_bus_off_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEEP) |-> (!bus_en_q && !snoop_ok_q));
  // R8
  stopg_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOPG) |=> (!svc_q[EV_BINIT] && !svc_q[EV_FLUSH]));
  // R7
  deep_from_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    $changed(state_q) && (state_q == ST_DEEP) |-> ($past(state_q) == ST_SLEEP));
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl import lps_pkg::*; #(
  parameter int ABSENT_LIMIT = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_in,
  input  logic              gate_all,
  input  logic              halt_exec,
  input  logic              stpclk_req,
  input  logic              slp_req,
  input  logic              snoop_hit,
  input  logic              snoop_done,
  input  logic [NUM_EV-1:0] evt_in,
  output logic [2:0]        state_out,
  output logic              core_clk_en,
  output logic              bus_clk_en,
  output logic              halt_cycle,
  output logic [NUM_EV-1:0] evt_svc,
  output logic              snoop_ok
);
  logic                 bclk_present;
  logic [NUM_LATCH-1:0] cap, drained, pend;
  logic                 release_w, clear_w;
  lps_state_e           st;

  lps_clkmon #(.LIMIT(ABSENT_LIMIT), .SYNC(SYNC_STAGES)) u_clkmon (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .present_q(bclk_present)
  );

  lps_pending #(.N(NUM_LATCH)) u_pending (
    .clk(clk), .rst(rst), .clear(clear_w), .release_i(release_w),
    .capture(cap), .pend_q(pend), .drained(drained)
  );

  lps_fsm u_fsm (
    .clk(clk), .rst(rst), .gate_all(gate_all), .bclk_present(bclk_present),
    .halt_exec(halt_exec), .stpclk_req(stpclk_req), .slp_req(slp_req),
    .snoop_hit(snoop_hit), .snoop_done(snoop_done), .evt(evt_in),
    .drained(drained), .cap(cap), .release_o(release_w), .clear_o(clear_w),
    .state_q(st), .core_en_q(core_clk_en), .bus_en_q(bus_clk_en),
    .halt_q(halt_cycle), .svc_q(evt_svc), .snoop_ok_q(snoop_ok)
  );

  assign state_out = st;

  // R9
  pend_only_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NORMAL) |-> (pend == '0));
endmodule

// File: tb/lps_ctrl_bench.sv
module lps_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk_in = 1'b0, bclk_run = 1'b1;
  logic gate_all = 1'b1, halt_exec = 1'b0, stpclk_req = 1'b0, slp_req = 1'b0;
  logic snoop_hit = 1'b0, snoop_done = 1'b0;
  logic [6:0] evt_in = '0;
  logic [2:0] state_out;
  logic core_clk_en, bus_clk_en, halt_cycle, snoop_ok;
  logic [6:0] evt_svc;

  int checks = 0, fails = 0;

  // reference model
  int         m_st = 1;
  bit         m_sgh = 0, m_snh = 0, m_bpres = 1;
  logic [3:0] m_pend = '0;
  int         e_st;
  logic [6:0] e_svc;
  bit         e_halt, e_core, e_bus, e_sok;

  lps_ctrl #(.ABSENT_LIMIT(LIMIT)) u_lps_ctrl (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .gate_all(gate_all),
    .halt_exec(halt_exec), .stpclk_req(stpclk_req), .slp_req(slp_req),
    .snoop_hit(snoop_hit), .snoop_done(snoop_done), .evt_in(evt_in),
    .state_out(state_out), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .halt_cycle(halt_cycle), .evt_svc(evt_svc), .snoop_ok(snoop_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (bclk_run) bclk_in <= ~bclk_in;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_next();
    int nst = m_st;
    bit drain = 0, clr = 0;
    e_svc = '0; e_halt = 0;
    if (m_st == 1) begin
      e_svc = evt_in;
      if (evt_in[6]) m_pend = '0;
      if (stpclk_req) begin nst = 3; m_sgh = 0; end
      else if (halt_exec) begin nst = 2; e_halt = 1; end
    end else if (m_st == 2) begin
      if (evt_in[6]) begin nst = 1; e_svc = 7'h40; clr = 1; end
      else if ((evt_in & 7'h1F) != 0) begin nst = 1; e_svc = evt_in & 7'h3F; drain = 1; end
      else begin
        e_svc[5] = evt_in[5];
        if (stpclk_req) begin nst = 3; m_sgh = 1; end
        else if (snoop_hit) begin nst = 4; m_snh = 1; end
      end
    end else if (m_st == 3 || m_st == 4) begin
      if (evt_in[6]) begin e_svc[6] = 1; clr = 1; end
      else m_pend = m_pend | evt_in[3:0];
      if (m_st == 3) begin
        if (!stpclk_req) nst = m_sgh ? 2 : 1;
        else if (slp_req) nst = 5;
        else if (snoop_hit) begin nst = 4; m_snh = 0; end
      end else if (snoop_done) nst = m_snh ? 2 : 3;
      if (nst == 1) drain = 1;
    end else if (m_st == 5) begin
      if (!slp_req) nst = 3; else if (!m_bpres) nst = 6;
    end else if (m_st == 6) begin
      if (m_bpres) nst = 5;
    end
    if (clr) m_pend = '0;
    if (drain && !clr) begin e_svc[3:0] = e_svc[3:0] | m_pend; m_pend = '0; end
    m_st   = nst;
    e_core = !(gate_all && (nst == 3 || nst == 5 || nst == 6));
    e_bus  = (nst != 6);
    e_sok  = !(nst == 5 || nst == 6);
    e_st   = nst;
  endtask

  // inputs were set at a negedge; one posedge later compare, return at negedge
  task automatic step(input bit chk);
    model_next();
    @(posedge clk); #1;
    if (chk) begin
      check("R2/R5/R6 state", state_out, e_st);
      check("R9 service strobes", evt_svc, e_svc);
      check("R2 halt strobe", halt_cycle, e_halt);
      check("R11 core clock enable", core_clk_en, e_core);
      check("R10 bus enable and snoop flag", {bus_clk_en, snoop_ok}, {e_bus, e_sok});
    end
    @(negedge clk);
    evt_in = '0; halt_exec = 0; snoop_hit = 0; snoop_done = 0;
  endtask

  initial begin
    int unsigned r;
    int cnt;
    r = $urandom(32'h5EED_0042);
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 state", state_out, 1);
    check("R1 enables", {core_clk_en, bus_clk_en, snoop_ok}, 3'b111);
    check("R1 strobes", {evt_svc, halt_cycle}, 0);

    // R13 normal services directly, reset keeps normal
    evt_in = 7'h45; step(1);
    check("R13 normal strobes", evt_svc, 7'h45);
    // R2 halt entry
    halt_exec = 1; step(1);
    check("R2 halt pulse", {state_out, halt_cycle}, {3'd2, 1'b1});
    step(1);
    check("R2 halt pulse one cycle", halt_cycle, 0);
    // R4 flush in halt stays
    evt_in = 7'h20; step(1);
    check("R4 flush serviced", {state_out, evt_svc}, {3'd2, 7'h20});
    // R6 snoop from halt and back
    snoop_hit = 1; step(1);
    check("R6 snoop entry", state_out, 4);
    snoop_done = 1; step(1);
    check("R6 return to halt", state_out, 2);
    // R5 stop-grant from halt returns to halt
    stpclk_req = 1; step(1);
    check("R5 stopg from halt", state_out, 3);
    // R8 binit and flush ignored
    evt_in = 7'h30; step(1);
    check("R8 ignored", {state_out, evt_svc}, {3'd3, 7'h00});
    stpclk_req = 0; step(1);
    check("R5 back to halt", state_out, 2);
    // R3 wake from halt with NMI plus flush
    evt_in = 7'h24; step(1);
    check("R3 wake", {state_out, evt_svc}, {3'd1, 7'h24});
    // R9 repeated SMI in stop-grant gives one strobe on return
    stpclk_req = 1; step(1);
    evt_in = 7'h01; step(1);
    evt_in = 7'h01; step(1);
    evt_in = 7'h08; step(1);
    check("R9 held while stopped", evt_svc, 0);
    stpclk_req = 0; step(1);
    check("R9 replay once", {state_out, evt_svc}, {3'd1, 7'h09});
    step(1);
    check("R9 no second replay", evt_svc, 0);
    // R8 reset in stop-grant discards pending
    stpclk_req = 1; step(1);
    evt_in = 7'h02; step(1);
    evt_in = 7'h40; step(1);
    check("R8 reset stays stopg", {state_out, evt_svc}, {3'd3, 7'h40});
    stpclk_req = 0; step(1);
    check("R8 pending discarded", {state_out, evt_svc}, {3'd1, 7'h00});
    // R7 and R12 sleep and deep sleep
    stpclk_req = 1; step(1);
    slp_req = 1; step(1);
    check("R7 sleep", state_out, 5);
    evt_in = 7'h7F; snoop_hit = 1; step(1);
    check("R10 sleep ignores", {state_out, evt_svc, snoop_ok}, {3'd5, 7'h00, 1'b0});
    bclk_run = 0;
    cnt = 0;
    while (state_out != 3'd6 && cnt < 40) begin step(0); cnt++; end
    check("R12 deep entry window", (cnt >= LIMIT && cnt <= LIMIT + 6) ? 1 : 0, 1);
    m_st = 6; m_bpres = 0;
    evt_in = 7'h7F; step(1);
    check("R10 deep ignores", {bus_clk_en, evt_svc}, {1'b0, 7'h00});
    bclk_run = 1;
    cnt = 0;
    while (state_out != 3'd5 && cnt < 40) begin step(0); cnt++; end
    check("R7 deep returns to sleep", (state_out == 3'd5 && cnt <= 8) ? 1 : 0, 1);
    m_st = 5; m_bpres = 1;
    slp_req = 0; step(1);
    check("R7 sleep to stopg", state_out, 3);
    gate_all = 0; step(1);
    check("R11 gating off", core_clk_en, 1);
    gate_all = 1; stpclk_req = 0; step(1);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(11) == 0) stpclk_req = ~stpclk_req;
      if ($urandom_range(9) == 0)  slp_req = ~slp_req;
      if ($urandom_range(39) == 0) gate_all = ~gate_all;
      halt_exec  = ($urandom_range(5) == 0);
      snoop_hit  = ($urandom_range(7) == 0);
      snoop_done = ($urandom_range(3) == 0);
      for (int b = 0; b < 7; b++) evt_in[b] = ($urandom_range(b == 6 ? 40 : 15) == 0);
      step(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule